// File: doc/BRIEF.md
# Serial Timing Frame Receiver and Dispatcher

This block sits on a single serial timing line and turns the bit stream into 32-bit timing frames. The line carries one bit per cell, with a level change in the middle of every cell. A frame begins after a quiet spell on the line. It opens with a start cell and then carries 32 data bits, most significant first. The receiver checks every cell for its mid-cell change and throws away any frame that breaks that rule, including one that stops early.

Each good frame is split into four fields: a 4-bit machine selector, a 4-bit kind, an 8-bit code and a 16-bit payload. The kind field sends the frame down one of several paths. Millisecond ticks and general events each get their own one-clock strobe, so that downstream counters can be loaded or triggered and interrupts raised. Two time-of-day frames are joined into one 32-bit seconds value, which is published in a single step. Telegram parameters are written into the hidden half of a two-bank store, and readers see only the published half. A dedicated telegram code swaps the two banks.

Top module: `timing_frame_rx`

## Requirements
- R1: Each bit cell lasts 2*HALF_CELL clocks. A 1 is high for the first half and low for the second, and a 0 is the reverse. The idle line is low.
- R2: A frame starts only on a rising edge that follows more than 2*CELL clocks (two cells) with no line transition. The start cell must decode as 1, and the 32 data bits follow MSB first. A rising edge after a shorter quiet spell starts nothing.
- R3: For each accepted frame, `frm_valid` pulses for one clock. The fields are split as bits 31:28 to `frm_acc`, 27:24 to `frm_type`, 23:16 to `frm_code` and 15:0 to `frm_payload`, and they hold until the next frame.
- R4: If any cell of a frame lacks its mid-cell change, or the start cell decodes as 0, or the frame stops early, `code_err` pulses for one clock. No `frm_valid` and no per-kind strobe is produced, and the receiver waits for a new quiet spell.
- R5: A frame of kind 3 pulses `ms_tick` together with `frm_valid`.
- R6: A frame of kind 5 pulses `evt_strobe` together with `frm_valid`. The event code and payload appear on `frm_code` and `frm_payload`.
- R7: A kind-1 frame stores its payload as the pending upper 16 seconds bits. A following kind-2 frame that finds a pending value sets `utc_sec` to {upper, kind-2 payload} and pulses `utc_strobe`. Each kind-2 frame clears the pending value, and frames of other kinds in between leave it in place.
- R8: A kind-2 frame with no pending upper half leaves `utc_sec` unchanged and gives no `utc_strobe`.
- R9: `utc_sec` changes only in the cycle that `utc_strobe` is high. A kind-1 frame on its own leaves it unchanged.
- R10: A kind-4 frame whose code is below TGM_DEPTH writes its payload into entry `code` of the hidden bank and pulses `tgm_strobe`. The read port `tgm_rd_data[tgm_rd_addr]` shows only the published bank, so such a write does not change it.
- R11: A kind-4 frame with code 0xFF swaps the published and hidden banks and pulses `tgm_ready` for one clock. The read port then shows the values written before the swap.
- R12: Frames of kind 0 or 6 to 15 give `frm_valid` but no per-kind strobe.
- R13: Reset clears all strobes, `utc_sec`, both telegram banks and the field outputs. After reset the receiver needs a quiet spell before it accepts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial timing line |
| frm_valid | output | 1 | One-clock pulse per accepted frame |
| frm_acc | output | 4 | Machine selector field |
| frm_type | output | 4 | Frame kind field |
| frm_code | output | 8 | Code field |
| frm_payload | output | 16 | Payload field |
| code_err | output | 1 | Pulse on a coding error or truncated frame |
| ms_tick | output | 1 | Millisecond frame strobe |
| evt_strobe | output | 1 | General event strobe |
| utc_strobe | output | 1 | Time-of-day update strobe |
| utc_sec | output | 32 | Assembled seconds value |
| tgm_strobe | output | 1 | Telegram parameter written |
| tgm_ready | output | 1 | Telegram banks swapped |
| tgm_rd_addr | input | TGM_AW | Published telegram read index |
| tgm_rd_data | output | 16 | Published telegram entry |

## Verification
The line passes through two synchronizer flops before it reaches the receiver. The receiver registers a frame one clock after the second-half sample of the final cell, and the dispatcher registers the fields and every per-kind strobe one clock after that, so all of a frame's results appear in the same cycle; `code_err` comes one clock earlier than a strobe would. The bench follows each frame with three idle cells, which is longer than that pipeline, and only then compares pulse counters, field outputs, the seconds value and the published telegram entries against a model derived from the requirements. Because the line is driven and results are read on the falling clock edge, no check depends on the order of events at the active edge.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

    localparam int FRAME_BITS = 32;

    // frame kinds
    localparam logic [3:0] K_UTC_HI = 4'h1;
    localparam logic [3:0] K_UTC_LO = 4'h2;
    localparam logic [3:0] K_MSEC   = 4'h3;
    localparam logic [3:0] K_TGM    = 4'h4;
    localparam logic [3:0] K_EVENT  = 4'h5;

    localparam logic [7:0] TGM_SWAP_CODE = 8'hFF;

    typedef struct packed {
        logic [3:0]  acc;
        logic [3:0]  kind;
        logic [7:0]  code;
        logic [15:0] payload;
    } frame_t;

    typedef struct packed {
        logic utc_hi;
        logic utc_lo;
        logic msec;
        logic tgm_wr;
        logic tgm_swap;
        logic evt;
    } route_t;

    typedef enum logic {ST_HUNT, ST_RECV} rx_state_e;

    function automatic route_t route_frame(frame_t f);
        route_t r;
        r = '0;
        case (f.kind)
            K_UTC_HI: r.utc_hi = 1'b1;
            K_UTC_LO: r.utc_lo = 1'b1;
            K_MSEC:   r.msec   = 1'b1;
            K_EVENT:  r.evt    = 1'b1;
            K_TGM: begin
                if (f.code == TGM_SWAP_CODE) r.tgm_swap = 1'b1;
                else                         r.tgm_wr   = 1'b1;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tfr_line_rx.sv
module tfr_line_rx
    import tfr_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ser_in,
    output logic   rx_vld,
    output frame_t rx_frame,
    output logic   rx_err
);
    localparam int CELL  = 2 * HALF;
    localparam int GAP   = 2 * CELL + 1;
    localparam int IW    = $clog2(GAP + 1);
    localparam int PW    = $clog2(CELL);
    localparam int NCELL = FRAME_BITS + 1;
    localparam int BW    = $clog2(NCELL + 1);
    localparam logic [PW-1:0] P_S1   = PW'(HALF / 2);
    localparam logic [PW-1:0] P_S2   = PW'(HALF + HALF / 2);
    localparam logic [PW-1:0] P_LAST = PW'(CELL - 1);
    localparam logic [BW-1:0] B_LAST = BW'(NCELL - 1);
    localparam logic [IW-1:0] I_GAP  = IW'(GAP);

    logic [1:0]            sync_q;
    logic                  ln_q;
    logic                  ln;
    logic                  ln_edge;
    logic [IW-1:0]         idle_cnt;
    logic                  armed;
    rx_state_e             st;
    logic [PW-1:0]         pos;
    logic [BW-1:0]         bitn;
    logic                  h1_smp;
    logic [FRAME_BITS-2:0] shreg;

    assign ln      = sync_q[1];
    assign ln_edge = ln ^ ln_q;
    assign armed   = (idle_cnt == I_GAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            ln_q     <= 1'b0;
            idle_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], ser_in};
            ln_q   <= ln;
            if (ln_edge)            idle_cnt <= '0;
            else if (!armed)        idle_cnt <= idle_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_HUNT;
            pos      <= '0;
            bitn     <= '0;
            h1_smp   <= 1'b0;
            shreg    <= '0;
            rx_vld   <= 1'b0;
            rx_err   <= 1'b0;
            rx_frame <= '0;
        end else begin
            rx_vld <= 1'b0;
            rx_err <= 1'b0;
            case (st)
                ST_HUNT: begin
                    if (armed && ln && !ln_q) begin
                        st   <= ST_RECV;
                        pos  <= PW'(1);
                        bitn <= '0;
                    end
                end
                default: begin
                    pos <= (pos == P_LAST) ? '0 : pos + 1'b1;
                    if (pos == P_LAST) bitn <= bitn + 1'b1;
                    if (pos == P_S1) h1_smp <= ln;
                    if (pos == P_S2) begin
                        if ((ln == h1_smp) || (bitn == '0 && !h1_smp)) begin
                            rx_err <= 1'b1;
                            st     <= ST_HUNT;
                        end else if (bitn == B_LAST) begin
                            rx_vld   <= 1'b1;
                            rx_frame <= frame_t'({shreg, h1_smp});
                            st       <= ST_HUNT;
                        end else if (bitn != '0) begin
                            shreg <= {shreg[FRAME_BITS-3:0], h1_smp};
                        end
                    end
                end
            endcase
        end
    end

    // R2
    start_needs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RECV && $past(st) == ST_HUNT) |-> $past(armed));

    // R4
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> !rx_vld);

endmodule

// File: rtl/tfr_utc_asm.sv
module tfr_utc_asm (
    input  logic        clk,
    input  logic        rst,
    input  logic        hi_we,
    input  logic        lo_we,
    input  logic [15:0] payload,
    output logic [31:0] utc_sec,
    output logic        utc_strobe
);
    logic [15:0] hi_q;
    logic        hi_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q       <= '0;
            hi_ok      <= 1'b0;
            utc_sec    <= '0;
            utc_strobe <= 1'b0;
        end else begin
            utc_strobe <= 1'b0;
            if (hi_we) begin
                hi_q  <= payload;
                hi_ok <= 1'b1;
            end else if (lo_we) begin
                hi_ok <= 1'b0;
                if (hi_ok) begin
                    utc_sec    <= {hi_q, payload};
                    utc_strobe <= 1'b1;
                end
            end
        end
    end

    // R9
    utc_atomic_chk: assert property (@(posedge clk) disable iff (rst)
        (utc_sec != $past(utc_sec)) |-> utc_strobe);

    // R7
    utc_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
        utc_strobe |-> $past(lo_we));

endmodule

// File: rtl/tfr_tgm_buf.sv
module tfr_tgm_buf #(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          swap,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          ready
);
    logic                 pub_sel;
    logic [1:0][DW-1:0]   bank_rd;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DW-1:0] ent [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            end else if (wr_en && (pub_sel != 1'(b))) begin
                ent[wr_addr] <= wr_data;
            end
        end
        assign bank_rd[b] = ent[rd_addr];
    end

    assign rd_data = bank_rd[pub_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            pub_sel <= 1'b0;
            ready   <= 1'b0;
        end else begin
            ready <= swap;
            if (swap) pub_sel <= ~pub_sel;
        end
    end

    // R11
    swap_flip_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pub_sel != $past(pub_sel)));

    // R11
    no_swap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> $stable(pub_sel));

    // R10
    pub_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(rd_addr) && !ready) |-> $stable(rd_data));

endmodule

// File: rtl/timing_frame_rx.sv
module timing_frame_rx
    import tfr_pkg::*;
#(
    parameter int HALF_CELL  = 4,
    parameter int TGM_DEPTH  = 16,
    localparam int TGM_AW    = $clog2(TGM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    output logic              frm_valid,
    output logic [3:0]        frm_acc,
    output logic [3:0]        frm_type,
    output logic [7:0]        frm_code,
    output logic [15:0]       frm_payload,
    output logic              code_err,
    output logic              ms_tick,
    output logic              evt_strobe,
    output logic              utc_strobe,
    output logic [31:0]       utc_sec,
    output logic              tgm_strobe,
    output logic              tgm_ready,
    input  logic [TGM_AW-1:0] tgm_rd_addr,
    output logic [15:0]       tgm_rd_data
);
    logic   rx_vld;
    logic   rx_err;
    frame_t rx_frame;
    route_t rt;
    logic   tgm_we;

    tfr_line_rx #(.HALF(HALF_CELL)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .rx_vld   (rx_vld),
        .rx_frame (rx_frame),
        .rx_err   (rx_err)
    );

    assign code_err = rx_err;
    assign rt       = rx_vld ? route_frame(rx_frame) : '0;
    assign tgm_we   = rt.tgm_wr && (int'(rx_frame.code) < TGM_DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_valid   <= 1'b0;
            frm_acc     <= '0;
            frm_type    <= '0;
            frm_code    <= '0;
            frm_payload <= '0;
            ms_tick     <= 1'b0;
            evt_strobe  <= 1'b0;
            tgm_strobe  <= 1'b0;
        end else begin
            frm_valid  <= rx_vld;
            ms_tick    <= rt.msec;
            evt_strobe <= rt.evt;
            tgm_strobe <= tgm_we;
            if (rx_vld) begin
                frm_acc     <= rx_frame.acc;
                frm_type    <= rx_frame.kind;
                frm_code    <= rx_frame.code;
                frm_payload <= rx_frame.payload;
            end
        end
    end

    tfr_utc_asm u_utc (
        .clk        (clk),
        .rst        (rst),
        .hi_we      (rt.utc_hi),
        .lo_we      (rt.utc_lo),
        .payload    (rx_frame.payload),
        .utc_sec    (utc_sec),
        .utc_strobe (utc_strobe)
    );

    tfr_tgm_buf #(.DEPTH(TGM_DEPTH), .DW(16)) u_tgm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tgm_we),
        .wr_addr (rx_frame.code[TGM_AW-1:0]),
        .wr_data (rx_frame.payload),
        .swap    (rt.tgm_swap),
        .rd_addr (tgm_rd_addr),
        .rd_data (tgm_rd_data),
        .ready   (tgm_ready)
    );

    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ms_tick, evt_strobe, tgm_strobe, tgm_ready, utc_strobe}));

    // R12
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && (frm_type == 4'h0 || frm_type > K_EVENT))
        |-> !(ms_tick || evt_strobe || tgm_strobe || tgm_ready || utc_strobe));

    // R5
    strobe_has_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (ms_tick || evt_strobe || tgm_strobe || tgm_ready || utc_strobe) |-> frm_valid);

    // R4
    err_no_publish_chk: assert property (@(posedge clk) disable iff (rst)
        code_err |=> !frm_valid);

endmodule

// File: tb/timing_frame_rx_bench.sv
module timing_frame_rx_bench;
    localparam int HALF = 4;
    localparam int CELL = 2 * HALF;
    localparam int NV   = 13;
    localparam logic [31:0] VEC [NV] = '{
        32'h21006543, 32'h22002101, 32'h230107D0, 32'h3542BEEF,
        32'h22001111, 32'h2403A5A5, 32'h240F1234, 32'h24FF0000,
        32'h27AB00FF, 32'h2100FFFF, 32'h23020001, 32'h22000000,
        32'hF0AA5555
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic [3:0] rd_addr = 4'd0;
    logic frm_valid, code_err, ms_tick, evt_strobe, utc_strobe, tgm_strobe, tgm_ready;
    logic [3:0] frm_acc, frm_type;
    logic [7:0] frm_code;
    logic [15:0] frm_payload, tgm_rd_data;
    logic [31:0] utc_sec;

    always #4 clk = ~clk;

    timing_frame_rx #(.HALF_CELL(HALF), .TGM_DEPTH(16)) u_timing_frame_rx (
        .clk(clk), .rst(rst), .ser_in(ser_in),
        .frm_valid(frm_valid), .frm_acc(frm_acc), .frm_type(frm_type),
        .frm_code(frm_code), .frm_payload(frm_payload), .code_err(code_err),
        .ms_tick(ms_tick), .evt_strobe(evt_strobe), .utc_strobe(utc_strobe),
        .utc_sec(utc_sec), .tgm_strobe(tgm_strobe), .tgm_ready(tgm_ready),
        .tgm_rd_addr(rd_addr), .tgm_rd_data(tgm_rd_data)
    );

    int n_chk = 0, n_bad = 0;
    int c_frm = 0, c_err = 0, c_ms = 0, c_evt = 0, c_utc = 0, c_tgw = 0, c_rdy = 0;

    always @(posedge clk) begin
        if (rst) begin
            c_frm <= 0; c_err <= 0; c_ms <= 0; c_evt <= 0;
            c_utc <= 0; c_tgw <= 0; c_rdy <= 0;
        end else begin
            if (frm_valid)  c_frm <= c_frm + 1;
            if (code_err)   c_err <= c_err + 1;
            if (ms_tick)    c_ms  <= c_ms + 1;
            if (evt_strobe) c_evt <= c_evt + 1;
            if (utc_strobe) c_utc <= c_utc + 1;
            if (tgm_strobe) c_tgw <= c_tgw + 1;
            if (tgm_ready)  c_rdy <= c_rdy + 1;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        ser_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cell(input logic b);
        hold(b, HALF);
        hold(!b, HALF);
    endtask

    // start cell, nbits data bits MSB first, then a low gap
    task automatic send_word(input logic [31:0] w, input int nbits, input int gap);
        send_cell(1'b1);
        for (int i = 31; i > 31 - nbits; i--) send_cell(w[i]);
        hold(1'b0, gap);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] m_fill [16];
        logic [15:0] m_pub [16];
        logic [15:0] m_hi;
        logic [15:0] tmp;
        bit          m_ok;
        logic [31:0] m_utc;
        int s_frm, s_err, s_ms, s_evt, s_utc, s_tgw, s_rdy;
        logic [31:0] w;
        logic [3:0]  t;
        int e_utc, e_tgw, e_rdy;
        string ul;

        for (int i = 0; i < 16; i++) begin m_fill[i] = '0; m_pub[i] = '0; end
        m_hi = '0; m_ok = 0; m_utc = '0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        chk("R13 frm_valid", {31'b0, frm_valid}, 32'd0);
        chk("R13 strobes", {27'b0, ms_tick, evt_strobe, utc_strobe, tgm_strobe, tgm_ready}, 32'd0);
        chk("R13 utc_sec", utc_sec, 32'd0);
        chk("R13 telegram read", {16'b0, tgm_rd_data}, 32'd0);
        chk("R13 fields", {frm_acc, frm_type, frm_code, frm_payload}, 32'd0);

        hold(1'b0, 3 * CELL);

        // vector table: R1 R3 and routing
        for (int v = 0; v < NV; v++) begin
            w = VEC[v];
            t = w[27:24];
            s_frm = c_frm; s_err = c_err; s_ms = c_ms; s_evt = c_evt;
            s_utc = c_utc; s_tgw = c_tgw; s_rdy = c_rdy;
            send_word(w, 32, 3 * CELL);

            e_utc = 0; e_tgw = 0; e_rdy = 0; ul = "R7";
            case (t)
                4'h1: begin m_hi = w[15:0]; m_ok = 1; ul = "R9"; end
                4'h2: begin
                    if (m_ok) begin m_utc = {m_hi, w[15:0]}; e_utc = 1; end
                    else ul = "R8";
                    m_ok = 0;
                end
                4'h4: begin
                    if (w[23:16] == 8'hFF) begin
                        e_rdy = 1;
                        for (int i = 0; i < 16; i++) begin
                            tmp = m_pub[i]; m_pub[i] = m_fill[i]; m_fill[i] = tmp;
                        end
                    end else if (w[23:16] < 8'd16) begin
                        e_tgw = 1;
                        m_fill[w[19:16]] = w[15:0];
                    end
                end
                default: ;
            endcase

            chk("R1/R3 frame count", 32'(c_frm - s_frm), 32'd1);
            chk("R3 fields", {frm_acc, frm_type, frm_code, frm_payload}, w);
            chk("R4 no error", 32'(c_err - s_err), 32'd0);
            chk("R5/R12 ms_tick", 32'(c_ms - s_ms), (t == 4'h3) ? 32'd1 : 32'd0);
            chk("R6/R12 evt_strobe", 32'(c_evt - s_evt), (t == 4'h5) ? 32'd1 : 32'd0);
            chk({ul, " utc_strobe"}, 32'(c_utc - s_utc), 32'(e_utc));
            chk({ul, " utc_sec"}, utc_sec, m_utc);
            chk("R10 tgm_strobe", 32'(c_tgw - s_tgw), 32'(e_tgw));
            chk("R11 tgm_ready", 32'(c_rdy - s_rdy), 32'(e_rdy));
            rd_addr = 4'd3; #1;
            chk("R10/R11 telegram entry 3", {16'b0, tgm_rd_data}, {16'b0, m_pub[3]});
            rd_addr = 4'd15; #1;
            chk("R10/R11 telegram entry 15", {16'b0, tgm_rd_data}, {16'b0, m_pub[15]});
            @(negedge clk);
        end

        // R4: frame cut short after ten data bits
        s_frm = c_frm; s_err = c_err;
        send_word(32'h3500AAAA, 10, 3 * CELL);
        chk("R4 truncated err", 32'(c_err - s_err), 32'd1);
        chk("R4 truncated no frame", 32'(c_frm - s_frm), 32'd0);

        // R4: a cell without its mid-cell transition
        s_frm = c_frm; s_err = c_err; s_evt = c_evt;
        send_cell(1'b1);
        for (int i = 0; i < 5; i++) send_cell(1'b0);
        hold(1'b1, CELL);
        for (int i = 0; i < 5; i++) send_cell(1'b1);
        hold(1'b0, 3 * CELL);
        chk("R4 bad cell err", 32'(c_err - s_err), 32'd1);
        chk("R4 bad cell no frame", 32'(c_frm - s_frm), 32'd0);

        // R4: recovery with a good event frame
        send_word(32'h35110042, 32, 3 * CELL);
        chk("R4 recovery frame", 32'(c_frm - s_frm), 32'd1);
        chk("R6 recovery event", 32'(c_evt - s_evt), 32'd1);
        chk("R3 recovery fields", {frm_acc, frm_type, frm_code, frm_payload}, 32'h35110042);

        // R2: second frame follows too soon and must be ignored
        s_frm = c_frm; s_err = c_err; s_ms = c_ms; s_evt = c_evt;
        send_word(32'h23000001, 32, CELL);
        send_word(32'h35000007, 32, 3 * CELL);
        chk("R2 one frame only", 32'(c_frm - s_frm), 32'd1);
        chk("R2 first frame kept", {frm_acc, frm_type, frm_code, frm_payload}, 32'h23000001);
        chk("R2 ms tick", 32'(c_ms - s_ms), 32'd1);
        chk("R2 late event ignored", 32'(c_evt - s_evt), 32'd0);
        chk("R2 no error", 32'(c_err - s_err), 32'd0);

        // R13: reset after activity
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd_addr = 4'd3; #1;
        chk("R13 utc cleared", utc_sec, 32'd0);
        chk("R13 telegram cleared", {16'b0, tgm_rd_data}, 32'd0);

        summary();
        $finish;
    end

endmodule